// File: doc/BRIEF.md
# Target-mode bus instruction sequencer

This block runs the bus-control instructions of a script-driven bus controller while the controller acts as a target on the bus. An upstream fetch stage hands it one first instruction word at a time, qualified by `instr_valid`. The block accepts the word only while it is idle. It decodes the word and then either finishes at once, as the flag-updating instructions and the bus release do, or waits on abstract bus events: arbitration won or lost, selected, reselected, and a host abort bit.

Each legal instruction ends with a one-cycle `done` pulse. Alongside it, `next_sel` tells the fetch stage where the next instruction comes from: 0 means the sequential pointer and 1 means the jump-address register. The reselect instruction ends as soon as arbitration is won. The block does not wait for the reselection to finish; it raises a one-cycle reselect request that carries the destination ID.

The state machine has three states. IDLE accepts a word. ARBITRATE holds the arbitration request. WAIT_SELECT waits to be selected. The transitions are named as follows. IDLE→ARBITRATE happens on a reselect word. IDLE→WAIT_SELECT happens on a wait-select word. IDLE→IDLE happens on a disconnect, set, clear or illegal word. ARBITRATE→IDLE happens on a win, or when the block is preempted by a select or reselect. ARBITRATE→ARBITRATE happens on a loss or when nothing arrives. WAIT_SELECT→IDLE happens on an abort, a select or a reselect. WAIT_SELECT→WAIT_SELECT happens otherwise.

Top module: `tgt_bus_seq`

## Requirements
- R1: A word is legal only when bits 31:30 equal 2'b01 and the opcode in bits 29:27 is at most 3'b100. An accepted illegal word raises `illegal` for one cycle, starting the cycle after acceptance. It gives no `done`, changes no flag and leaves the block idle.
- R2: Opcode 000 (reselect) moves the block into arbitration. From the cycle after acceptance, `arb_req` is 1 and `arb_id` equals `own_id` until the instruction ends.
- R3: During arbitration, `arb_lost` has no visible effect. `arb_req` stays 1, and neither `done` nor any other status output rises.
- R4: `arb_won` during arbitration gives, one cycle later, `done`=1, `next_sel`=0 and `resel_req`=1, with `resel_dest` equal to bits 19:16 of the reselect word. `arb_req` then drops.
- R5: A `sel_evt` or `resel_evt` during arbitration, including one in the same cycle as `arb_won`, gives one cycle later `done`=1, `next_sel`=1 and no `resel_req`.
- R6: Opcode 001 (disconnect) pulses `release_all` together with `done`, with `next_sel`=0, one cycle after acceptance.
- R7: Opcode 010 (wait select) waits for an event. `abort_sig` ends the wait with `next_sel`=1. Otherwise `sel_evt` ends it with `next_sel`=0, and otherwise `resel_evt` ends it with `next_sel`=1. `done` comes one cycle after the event.
- R8: Opcode 011 (set) sets, and opcode 100 (clear) clears, each flag whose enable bit is 1: bit 10 for carry, bit 9 for target mode, bit 6 for ACK and bit 3 for ATN. Other flags are left alone. The new flag values appear together with `done`=1 and `next_sel`=0, one cycle after acceptance.
- R9: While the block is not idle (`idle`=0), `instr_valid` is ignored. A word offered during a wait changes no flag and does not end the wait.
- R10: After reset, `idle`=1, all flags are 0, and `done`, `arb_req`, `resel_req`, `release_all` and `illegal` are 0.
- R11: `done` lasts exactly one cycle for an instruction when no new word is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | First instruction word offered |
| instr_word | input | 32 | First instruction word |
| own_id | input | 4 | Stored bus ID of this controller |
| arb_won | input | 1 | Arbitration won |
| arb_lost | input | 1 | Arbitration lost |
| sel_evt | input | 1 | Selected by another device |
| resel_evt | input | 1 | Reselected by another device |
| abort_sig | input | 1 | Host abort signal bit |
| idle | output | 1 | Ready to accept a word |
| arb_req | output | 1 | Arbitration request |
| arb_id | output | 4 | ID asserted during arbitration |
| resel_req | output | 1 | One-cycle reselect start |
| resel_dest | output | 4 | Destination ID for reselect |
| release_all | output | 1 | Release all bus outputs |
| done | output | 1 | Instruction complete |
| next_sel | output | 1 | 0 for sequential fetch, 1 for jump |
| illegal | output | 1 | Illegal word rejected |
| flag_ack | output | 1 | ACK control bit |
| flag_atn | output | 1 | ATN control bit |
| flag_tgt | output | 1 | Target-mode control bit |
| flag_carry | output | 1 | ALU carry flag |

## Verification
The block computes every result on the clock edge that samples its cause. `done`, `next_sel`, `resel_req`, `release_all`, `illegal` and the flags therefore show up one cycle after the accepting edge or the event edge. `arb_req` and `idle` follow the state, which changes on the accepting edge. The bench drives every input on the falling edge and samples 1 ns after the next rising edge, so each check reads the cycle in which its result is due. It checks again one edge later to confirm that the pulses have ended and that waits hold while nothing arrives.

// File: rtl/tgt_seq_pkg.sv
package tgt_seq_pkg;

    localparam int DEST_W    = 4;
    localparam int NFLAG     = 4;
    localparam int TYPE_HI   = 31;
    localparam int TYPE_LO   = 30;
    localparam int OP_HI     = 29;
    localparam int OP_LO     = 27;
    localparam int DEST_LSB  = 16;
    localparam int EN_CARRY  = 10;
    localparam int EN_TGT    = 9;
    localparam int EN_ACK    = 6;
    localparam int EN_ATN    = 3;
    localparam logic [1:0] IO_TYPE = 2'b01;

    // flag vector order: [3] carry, [2] target mode, [1] ack, [0] atn
    localparam int F_CARRY = 3;
    localparam int F_TGT   = 2;
    localparam int F_ACK   = 1;
    localparam int F_ATN   = 0;

    typedef enum logic [2:0] {
        OP_RESEL   = 3'b000,
        OP_DISC    = 3'b001,
        OP_WAITSEL = 3'b010,
        OP_SET     = 3'b011,
        OP_CLR     = 3'b100
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_WAIT = 2'd2
    } st_e;

    typedef struct packed {
        logic              legal;
        logic [2:0]        op;
        logic [DEST_W-1:0] dest;
        logic [NFLAG-1:0]  mask;
    } dec_t;

endpackage

// File: rtl/tgt_seq_decode.sv
module tgt_seq_decode
    import tgt_seq_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);

    logic unused_bits;
    assign unused_bits = ^{word[26:20], word[15:11], word[8:7], word[5:4], word[2:0]};

    always_comb begin
        dec.op             = word[OP_HI:OP_LO];
        dec.legal          = (word[TYPE_HI:TYPE_LO] == IO_TYPE) && (word[OP_HI:OP_LO] <= OP_CLR);
        dec.dest           = word[DEST_LSB +: DEST_W];
        dec.mask           = '0;
        dec.mask[F_CARRY]  = word[EN_CARRY];
        dec.mask[F_TGT]    = word[EN_TGT];
        dec.mask[F_ACK]    = word[EN_ACK];
        dec.mask[F_ATN]    = word[EN_ATN];
    end

endmodule

// File: rtl/tgt_seq_flags.sv
module tgt_seq_flags #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          apply,
    input  logic          set_mode,
    input  logic [NF-1:0] mask,
    output logic [NF-1:0] flags
);

    for (genvar i = 0; i < NF; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (apply && mask[i])
                flags[i] <= set_mode;
        end
    end

    // R8: flags move only when a set or clear instruction applies them
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(flags));

endmodule

// File: rtl/tgt_seq_fsm.sv
module tgt_seq_fsm
    import tgt_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  dec_t              dec,
    input  logic [DEST_W-1:0] own_id,
    input  logic              arb_won,
    input  logic              arb_lost,
    input  logic              sel_evt,
    input  logic              resel_evt,
    input  logic              abort_sig,
    output logic              idle,
    output logic              arb_req,
    output logic [DEST_W-1:0] arb_id,
    output logic              resel_req,
    output logic [DEST_W-1:0] resel_dest,
    output logic              release_all,
    output logic              done,
    output logic              next_sel,
    output logic              illegal,
    output logic              flag_apply,
    output logic              flag_set
);

    st_e               state, nxt;
    logic              d_done, d_nsel, d_resel, d_rel, d_ill, cap_dest;
    logic [DEST_W-1:0] dest_q;

    always_comb begin
        nxt        = state;
        d_done     = 1'b0;
        d_nsel     = 1'b0;
        d_resel    = 1'b0;
        d_rel      = 1'b0;
        d_ill      = 1'b0;
        cap_dest   = 1'b0;
        flag_apply = 1'b0;
        flag_set   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (instr_valid) begin
                    if (!dec.legal) begin
                        d_ill = 1'b1;
                    end else begin
                        unique case (dec.op)
                            OP_RESEL: begin
                                nxt      = ST_ARB;
                                cap_dest = 1'b1;
                            end
                            OP_DISC: begin
                                d_rel  = 1'b1;
                                d_done = 1'b1;
                            end
                            OP_WAITSEL: nxt = ST_WAIT;
                            OP_SET: begin
                                flag_apply = 1'b1;
                                flag_set   = 1'b1;
                                d_done     = 1'b1;
                            end
                            OP_CLR: begin
                                flag_apply = 1'b1;
                                d_done     = 1'b1;
                            end
                            default: d_ill = 1'b1;
                        endcase
                    end
                end
            end
            ST_ARB: begin
                if (sel_evt || resel_evt) begin
                    nxt    = ST_IDLE;
                    d_done = 1'b1;
                    d_nsel = 1'b1;
                end else if (arb_won) begin
                    nxt     = ST_IDLE;
                    d_done  = 1'b1;
                    d_resel = 1'b1;
                end
            end
            ST_WAIT: begin
                if (abort_sig) begin
                    nxt    = ST_IDLE;
                    d_done = 1'b1;
                    d_nsel = 1'b1;
                end else if (sel_evt) begin
                    nxt    = ST_IDLE;
                    d_done = 1'b1;
                end else if (resel_evt) begin
                    nxt    = ST_IDLE;
                    d_done = 1'b1;
                    d_nsel = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            next_sel    <= 1'b0;
            resel_req   <= 1'b0;
            release_all <= 1'b0;
            illegal     <= 1'b0;
            dest_q      <= '0;
        end else begin
            done        <= d_done;
            next_sel    <= d_nsel;
            resel_req   <= d_resel;
            release_all <= d_rel;
            illegal     <= d_ill;
            if (cap_dest)
                dest_q <= dec.dest;
        end
    end

    assign idle       = (state == ST_IDLE);
    assign arb_req    = (state == ST_ARB);
    assign arb_id     = arb_req ? own_id : '0;
    assign resel_dest = dest_q;

    // R4: a reselect start always comes with a sequential completion
    a_r4_resel_done: assert property (@(posedge clk) disable iff (!rst_n)
        resel_req |-> (done && !next_sel));

    // R6: release strobe rides on a sequential completion
    a_r6_release_done: assert property (@(posedge clk) disable iff (!rst_n)
        release_all |-> (done && !next_sel));

    // R1: a rejected word never completes and leaves the block idle
    a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!done && idle));

    // R3: a lost arbitration (or nothing) keeps arbitrating silently
    a_r3_lost_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARB && !arb_won && !sel_evt && !resel_evt) |=> (arb_req && !done && !illegal));

    // R5: preemption during arbitration goes to the jump address
    a_r5_preempt_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARB && (sel_evt || resel_evt)) |=> (done && next_sel && !resel_req));

    // R7: the wait holds until some event arrives
    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !abort_sig && !sel_evt && !resel_evt) |=> (state == ST_WAIT && !done));

    // R3: losing arbitration is used only as an observed input
    a_r3_lost_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARB && arb_lost && !arb_won && !sel_evt && !resel_evt) |=> (state == ST_ARB));

endmodule

// File: rtl/tgt_bus_seq.sv
module tgt_bus_seq
    import tgt_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    input  logic [DEST_W-1:0] own_id,
    input  logic              arb_won,
    input  logic              arb_lost,
    input  logic              sel_evt,
    input  logic              resel_evt,
    input  logic              abort_sig,
    output logic              idle,
    output logic              arb_req,
    output logic [DEST_W-1:0] arb_id,
    output logic              resel_req,
    output logic [DEST_W-1:0] resel_dest,
    output logic              release_all,
    output logic              done,
    output logic              next_sel,
    output logic              illegal,
    output logic              flag_ack,
    output logic              flag_atn,
    output logic              flag_tgt,
    output logic              flag_carry
);

    dec_t             dec;
    logic             flag_apply, flag_set;
    logic [NFLAG-1:0] flags;

    tgt_seq_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    tgt_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .dec         (dec),
        .own_id      (own_id),
        .arb_won     (arb_won),
        .arb_lost    (arb_lost),
        .sel_evt     (sel_evt),
        .resel_evt   (resel_evt),
        .abort_sig   (abort_sig),
        .idle        (idle),
        .arb_req     (arb_req),
        .arb_id      (arb_id),
        .resel_req   (resel_req),
        .resel_dest  (resel_dest),
        .release_all (release_all),
        .done        (done),
        .next_sel    (next_sel),
        .illegal     (illegal),
        .flag_apply  (flag_apply),
        .flag_set    (flag_set)
    );

    tgt_seq_flags #(.NF(NFLAG)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (flag_apply),
        .set_mode (flag_set),
        .mask     (dec.mask),
        .flags    (flags)
    );

    assign flag_carry = flags[F_CARRY];
    assign flag_tgt   = flags[F_TGT];
    assign flag_ack   = flags[F_ACK];
    assign flag_atn   = flags[F_ATN];

    // R2: arbitration always carries this controller's own ID
    a_r2_arb_id: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req |-> (arb_id == own_id && !idle));

endmodule

// File: tb/tgt_bus_seq_tb.sv
module tgt_bus_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [31:0] instr_word;
    logic [3:0]  own_id;
    logic        arb_won, arb_lost, sel_evt, resel_evt, abort_sig;
    logic        idle, arb_req, resel_req, release_all, done, next_sel, illegal;
    logic [3:0]  arb_id, resel_dest;
    logic        flag_ack, flag_atn, flag_tgt, flag_carry;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    tgt_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .own_id(own_id), .arb_won(arb_won), .arb_lost(arb_lost), .sel_evt(sel_evt),
        .resel_evt(resel_evt), .abort_sig(abort_sig), .idle(idle), .arb_req(arb_req),
        .arb_id(arb_id), .resel_req(resel_req), .resel_dest(resel_dest),
        .release_all(release_all), .done(done), .next_sel(next_sel), .illegal(illegal),
        .flag_ack(flag_ack), .flag_atn(flag_atn), .flag_tgt(flag_tgt), .flag_carry(flag_carry)
    );

    function automatic logic [31:0] mk(input logic [1:0] ty, input logic [2:0] op,
                                       input logic [3:0] dest, input logic [3:0] en);
        // en order: carry, target, ack, atn
        return {ty, op, 7'b0, dest, 16'b0} | (32'(en[3]) << 10) | (32'(en[2]) << 9)
             | (32'(en[1]) << 6) | (32'(en[0]) << 3);
    endfunction

    function automatic logic [3:0] flv();
        return {flag_carry, flag_tgt, flag_ack, flag_atn};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
    endtask

    task automatic event_edge(input logic won, input logic lost, input logic sel,
                              input logic resel, input logic abrt);
        @(negedge clk);
        arb_won = won; arb_lost = lost; sel_evt = sel; resel_evt = resel; abort_sig = abrt;
        @(posedge clk);
        #1;
        arb_won = 0; arb_lost = 0; sel_evt = 0; resel_evt = 0; abort_sig = 0;
    endtask

    task automatic idle_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R10", "idle", idle, 1);
        check("R10", "flags", flv(), 0);
        check("R10", "pulses", {done, arb_req, resel_req, release_all, illegal}, 0);
    endtask

    task automatic t_set_clear();
        issue(mk(2'b01, 3'b011, 4'd0, 4'b1010));
        check("R8", "set done/nsel", {done, next_sel}, 2'b10);
        check("R8", "set flags", flv(), 4'b1010);
        idle_edge();
        check("R11", "done one cycle", done, 0);
        issue(mk(2'b01, 3'b011, 4'd0, 4'b0101));
        check("R8", "set more", flv(), 4'b1111);
        issue(mk(2'b01, 3'b100, 4'd0, 4'b1001));
        check("R8", "clear flags", flv(), 4'b0110);
        check("R8", "clear done", {done, next_sel}, 2'b10);
        idle_edge();
    endtask

    task automatic t_illegal();
        issue(mk(2'b10, 3'b011, 4'd0, 4'b1111));
        check("R1", "bad type illegal", illegal, 1);
        check("R1", "bad type no done", done, 0);
        check("R1", "bad type flags", flv(), 4'b0110);
        issue(mk(2'b01, 3'b101, 4'd0, 4'b1111));
        check("R1", "op101 illegal", {illegal, done, idle}, 3'b101);
        check("R1", "op101 flags", flv(), 4'b0110);
        idle_edge();
        check("R1", "illegal one cycle", illegal, 0);
    endtask

    task automatic t_disconnect();
        issue(mk(2'b01, 3'b001, 4'd0, 4'b0000));
        check("R6", "release/done/nsel", {release_all, done, next_sel}, 3'b110);
        idle_edge();
        check("R6", "release ends", release_all, 0);
    endtask

    task automatic t_resel_win();
        issue(mk(2'b01, 3'b000, 4'd9, 4'b0000));
        check("R2", "arb req", {arb_req, idle, done}, 3'b100);
        check("R2", "arb id", arb_id, 4'd5);
        event_edge(0, 1, 0, 0, 0);
        check("R3", "lost keeps arb", {arb_req, done, illegal, resel_req}, 4'b1000);
        event_edge(0, 1, 0, 0, 0);
        check("R3", "lost twice", {arb_req, done}, 2'b10);
        event_edge(1, 0, 0, 0, 0);
        check("R4", "won done/nsel/resel", {done, next_sel, resel_req}, 3'b101);
        check("R4", "resel dest", resel_dest, 4'd9);
        check("R4", "arb dropped", arb_req, 0);
        idle_edge();
        check("R11", "resel pulses end", {done, resel_req}, 2'b00);
    endtask

    task automatic t_resel_preempt();
        issue(mk(2'b01, 3'b000, 4'd3, 4'b0000));
        event_edge(1, 0, 1, 0, 0);
        check("R5", "sel beats won", {done, next_sel, resel_req}, 3'b110);
        issue(mk(2'b01, 3'b000, 4'd3, 4'b0000));
        event_edge(0, 0, 0, 1, 0);
        check("R5", "resel preempt", {done, next_sel, resel_req, arb_req}, 4'b1100);
        idle_edge();
    endtask

    task automatic t_wait_select();
        issue(mk(2'b01, 3'b010, 4'd0, 4'b0000));
        check("R7", "waiting", {idle, done}, 2'b00);
        issue(mk(2'b01, 3'b011, 4'd0, 4'b1111));
        check("R9", "word ignored flags", flv(), 4'b0110);
        check("R9", "word ignored wait", {idle, done}, 2'b00);
        event_edge(0, 0, 1, 0, 0);
        check("R7", "sel seq", {done, next_sel}, 2'b10);
        issue(mk(2'b01, 3'b010, 4'd0, 4'b0000));
        event_edge(0, 0, 0, 1, 0);
        check("R7", "resel jump", {done, next_sel}, 2'b11);
        issue(mk(2'b01, 3'b010, 4'd0, 4'b0000));
        event_edge(0, 0, 0, 0, 1);
        check("R7", "abort jump", {done, next_sel}, 2'b11);
        issue(mk(2'b01, 3'b010, 4'd0, 4'b0000));
        event_edge(0, 0, 1, 0, 1);
        check("R7", "abort beats sel", {done, next_sel}, 2'b11);
        issue(mk(2'b01, 3'b010, 4'd0, 4'b0000));
        event_edge(0, 0, 1, 1, 0);
        check("R7", "sel beats resel", {done, next_sel}, 2'b10);
        idle_edge();
        check("R7", "back idle", {idle, done}, 2'b10);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; own_id = 4'd5;
        arb_won = 0; arb_lost = 0; sel_evt = 0; resel_evt = 0; abort_sig = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_set_clear();
        t_illegal();
        t_disconnect();
        t_resel_win();
        t_resel_preempt();
        t_wait_select();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule